// File: doc/BRIEF.md
# UART Byte FIFO with Trigger and Watermark Flags

This block is the byte queue that sits between a serial line engine and the register interface of a UART, on either the transmit or the receive side. It holds up to 64 bytes in arrival order, reports how full it is, and raises flags and event pulses for the interrupt unit. The serializer and deserializer that feed it or drain it are outside the block.

Software sets a 6-bit trigger level. A trigger flag is raised whenever the fill level is at or above that level. A separate nearly-full flag is raised when fewer than two slots remain free. A driver that wants to write a two-byte sequence, such as a carriage return followed by a line feed, can test this flag once instead of testing the full flag twice. A write that arrives while the queue is full is dropped and reported as an overflow pulse. A synchronous flush input empties the queue, and a completion pulse follows so that a self-clearing control bit can drop.

Top module: `uart_trig_fifo`

## Requirements
- R1: During and after a reset (rst_n low at a rising edge), fill_level is 0, empty is 1, full, nearly_full, overflow_evt and flush_done are 0, and pop_data is 0.
- R2: Bytes leave in the order they were accepted. pop_data shows the oldest byte from the edge that takes a pop_req and holds it until the next pop or flush.
- R3: fill_level counts the bytes held (0 to 64). empty is 1 exactly when it is 0, and full is 1 exactly when it is 64. Each edge changes it by at most one.
- R4: trig_hit is 1 whenever fill_level is greater than or equal to trig_level, taken as an unsigned 6-bit number. A level of 0 therefore always sets it.
- R5: nearly_full is 1 whenever fill_level is 63 or more.
- R6: A push_valid while full is dropped. The stored bytes and fill_level are unchanged by it, and overflow_evt is 1 for the one cycle after that edge.
- R7: A pop_req while empty leaves fill_level at 0 and sets pop_data to 0.
- R8: A push and a pop on the same edge while full: the pop is taken, the push is dropped (fill becomes 63, overflow_evt pulses). While empty: the push is taken (fill becomes 1) and pop_data becomes 0.
- R9: path_flush at an edge empties the queue and clears pop_data. It overrides any push or pop on that edge, and flush_done is 1 for the one following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| path_flush | input | 1 | Synchronous flush of the queue |
| push_valid | input | 1 | Write push_data this cycle |
| push_data | input | 8 | Byte to enqueue |
| pop_req | input | 1 | Remove the oldest byte this cycle |
| trig_level | input | 6 | Trigger threshold |
| pop_data | output | 8 | Last byte removed (0 after an empty pop or a flush) |
| fill_level | output | 7 | Number of bytes held |
| empty | output | 1 | Queue holds no byte |
| full | output | 1 | Queue holds 64 bytes |
| trig_hit | output | 1 | fill_level >= trig_level |
| nearly_full | output | 1 | Fewer than two free slots |
| overflow_evt | output | 1 | One-cycle pulse after a dropped write |
| flush_done | output | 1 | One-cycle pulse after a flush |

## Verification
Every result of the block is due one rising edge after the stimulus that causes it. fill_level, pop_data, overflow_evt and flush_done are registered at that edge. The four flags are decoded from the registered count, so they settle in the same cycle. The bench changes inputs on the falling edge, lets one rising edge pass, and reads the outputs at the next falling edge. Pulse outputs are read a second time one cycle later to confirm that they last a single cycle.

// File: rtl/uart_fifo_pkg.sv
// Shared types for the UART byte queue.
// Assumes: nothing beyond IEEE 1800-2017.
package uart_fifo_pkg;

    // Decoded status of the queue.
    typedef struct packed {
        logic empty;
        logic full;
        logic trig;
        logic nearly_full;
    } fifo_flags_t;

    // What the pointer logic does on one edge.
    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } fifo_op_e;

endpackage

// File: rtl/uart_fifo_ptrs.sv
// Read/write pointers and occupancy count of the byte queue.
// A write is accepted only when the queue is not full and a read only when
// it is not empty. Flush and reset both return everything to zero.
// Assumes: DEPTH >= 2.
module uart_fifo_ptrs
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push_valid,
    input  logic              pop_req,
    output logic              do_push,
    output logic              do_pop,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0]  count
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [ADDR_W-1:0] wr_nxt;
    logic [ADDR_W-1:0] rd_nxt;
    fifo_op_e          op;

    // Pointer increment: plain wrap for powers of two, compare otherwise.
    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_npow2
            assign wr_nxt = (wr_ptr == ADDR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == ADDR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    // Qualify requests against the current occupancy.
    always_comb begin
        do_push = push_valid && (count != CNT_FULL);
        do_pop  = pop_req && (count != '0);
        op      = fifo_op_e'({do_push, do_pop});
    end

    // Advance pointers and count; flush takes priority over traffic.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            case (op)
                OP_PUSH: begin
                    wr_ptr <= wr_nxt;
                    count  <= count + 1'b1;
                end
                OP_POP: begin
                    rd_ptr <= rd_nxt;
                    count  <= count - 1'b1;
                end
                OP_BOTH: begin
                    wr_ptr <= wr_nxt;
                    rd_ptr <= rd_nxt;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/uart_fifo_store.sv
// Byte storage of the queue: one write port, one asynchronous read port.
// Assumes: the caller never writes a slot that is being read as valid data.
module uart_fifo_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store an accepted byte.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the slot at the read pointer.
    assign rdata = mem[raddr];

endmodule

// File: rtl/uart_fifo_flags.sv
// Decodes the occupancy count into the status flags.
// Assumes: CNT_W >= LVL_W, so the threshold fits the count width.
module uart_fifo_flags
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LVL_W = 6,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] count,
    input  logic [LVL_W-1:0] trig_level,
    output fifo_flags_t      flags
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_NF   = CNT_W'(DEPTH - 1);

    // Compare occupancy against fixed and programmable thresholds.
    always_comb begin
        flags.empty       = (count == '0);
        flags.full        = (count == CNT_FULL);
        flags.trig        = (count >= CNT_W'(trig_level));
        flags.nearly_full = (count >= CNT_NF);
    end

endmodule

// File: rtl/uart_trig_fifo.sv
// UART byte queue with trigger, nearly-full and overflow reporting.
// Registered pop data, registered event pulses, decoded flags.
// Assumes: rst_n and path_flush are synchronous to clk.
module uart_trig_fifo
    import uart_fifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    parameter int LVL_W  = 6,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              path_flush,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    input  logic [LVL_W-1:0]  trig_level,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  fill_level,
    output logic              empty,
    output logic              full,
    output logic              trig_hit,
    output logic              nearly_full,
    output logic              overflow_evt,
    output logic              flush_done
);

    logic              do_push;
    logic              do_pop;
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_ptr;
    logic [DATA_W-1:0] head_byte;
    fifo_flags_t       flags;

    uart_fifo_ptrs #(.DEPTH(DEPTH)) ptrs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (path_flush),
        .push_valid(push_valid),
        .pop_req   (pop_req),
        .do_push   (do_push),
        .do_pop    (do_pop),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .count     (fill_level)
    );

    uart_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
        .clk  (clk),
        .we   (do_push && !path_flush),
        .waddr(wr_ptr),
        .wdata(push_data),
        .raddr(rd_ptr),
        .rdata(head_byte)
    );

    uart_fifo_flags #(.DEPTH(DEPTH), .LVL_W(LVL_W)) flags_i (
        .count     (fill_level),
        .trig_level(trig_level),
        .flags     (flags)
    );

    assign empty       = flags.empty;
    assign full        = flags.full;
    assign trig_hit    = flags.trig;
    assign nearly_full = flags.nearly_full;

    // Capture the departing byte; an empty pop yields zero.
    always_ff @(posedge clk) begin
        if (!rst_n || path_flush) pop_data <= '0;
        else if (pop_req)         pop_data <= do_pop ? head_byte : '0;
    end

    // One-cycle pulse for a write that found the queue full.
    always_ff @(posedge clk) begin
        if (!rst_n || path_flush) overflow_evt <= 1'b0;
        else                      overflow_evt <= push_valid && flags.full;
    end

    // One-cycle pulse marking the end of a flush.
    always_ff @(posedge clk) begin
        if (!rst_n) flush_done <= 1'b0;
        else        flush_done <= path_flush;
    end

endmodule

// File: rtl/uart_trig_fifo_chk.sv
// Temporal checks on the byte queue, attached by bind.
module uart_trig_fifo_chk #(
    parameter int DATA_W = 8,
    parameter int LVL_W  = 6,
    parameter int CNT_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              path_flush,
    input logic              push_valid,
    input logic              pop_req,
    input logic [LVL_W-1:0]  trig_level,
    input logic [DATA_W-1:0] pop_data,
    input logic [CNT_W-1:0]  fill_level,
    input logic              empty,
    input logic              full,
    input logic              trig_hit,
    input logic              nearly_full,
    input logic              overflow_evt,
    input logic              flush_done
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (fill_level == '0 && empty && !full && !overflow_evt && !flush_done && pop_data == '0));

    // R3
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R4
    trig_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_hit == (fill_level >= CNT_W'(trig_level)));

    // R5
    nearly_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> nearly_full);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && full && !path_flush) |=> overflow_evt);

    // R6
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && full && !pop_req && !path_flush) |=> full);

    // R7
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !push_valid && !path_flush) |=> (empty && pop_data == '0));

    // R9
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        path_flush |=> (empty && flush_done && !overflow_evt));

endmodule

bind uart_trig_fifo uart_trig_fifo_chk #(
    .DATA_W(DATA_W), .LVL_W(LVL_W), .CNT_W(CNT_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .path_flush  (path_flush),
    .push_valid  (push_valid),
    .pop_req     (pop_req),
    .trig_level  (trig_level),
    .pop_data    (pop_data),
    .fill_level  (fill_level),
    .empty       (empty),
    .full        (full),
    .trig_hit    (trig_hit),
    .nearly_full (nearly_full),
    .overflow_evt(overflow_evt),
    .flush_done  (flush_done)
);

// File: tb/uart_trig_fifo_tb.sv
// Directed bench for the UART byte queue: one task per scenario.
module uart_trig_fifo_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       path_flush = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic       pop_req = 1'b0;
    logic [5:0] trig_level = 6'd1;
    logic [7:0] pop_data;
    logic [6:0] fill_level;
    logic       empty, full, trig_hit, nearly_full, overflow_evt, flush_done;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    uart_trig_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .path_flush(path_flush),
        .push_valid(push_valid), .push_data(push_data), .pop_req(pop_req),
        .trig_level(trig_level), .pop_data(pop_data), .fill_level(fill_level),
        .empty(empty), .full(full), .trig_hit(trig_hit),
        .nearly_full(nearly_full), .overflow_evt(overflow_evt),
        .flush_done(flush_done)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One rising edge, then settle at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push_one(input logic [7:0] b);
        push_valid = 1'b1; push_data = b;
        step();
        push_valid = 1'b0;
    endtask

    task automatic pop_one();
        pop_req = 1'b1;
        step();
        pop_req = 1'b0;
    endtask

    task automatic flush_q();
        path_flush = 1'b1;
        step();
        path_flush = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        check("R1", "fill", int'(fill_level), 0);
        check("R1", "empty", int'(empty), 1);
        check("R1", "full", int'(full), 0);
        check("R1", "nearly_full", int'(nearly_full), 0);
        check("R1", "overflow", int'(overflow_evt), 0);
        check("R1", "flush_done", int'(flush_done), 0);
        check("R1", "pop_data", int'(pop_data), 0);
    endtask

    task automatic t_order();
        push_one(8'h11); push_one(8'h22); push_one(8'h33);
        check("R3", "fill after 3 pushes", int'(fill_level), 3);
        check("R3", "empty with data", int'(empty), 0);
        pop_one(); check("R2", "first byte", int'(pop_data), 'h11);
        step();    check("R2", "byte held", int'(pop_data), 'h11);
        pop_one(); check("R2", "second byte", int'(pop_data), 'h22);
        pop_one(); check("R2", "third byte", int'(pop_data), 'h33);
        check("R3", "empty after drain", int'(empty), 1);
    endtask

    task automatic t_trigger();
        trig_level = 6'd4;
        for (int i = 0; i < 3; i++) push_one(8'(i));
        check("R4", "trig below level", int'(trig_hit), 0);
        push_one(8'h04);
        check("R4", "trig at level", int'(trig_hit), 1);
        trig_level = 6'd63; #1;
        check("R4", "trig level 63", int'(trig_hit), 0);
        flush_q();
        trig_level = 6'd0; #1;
        check("R4", "trig level 0 empty", int'(trig_hit), 1);
        trig_level = 6'd63;
    endtask

    task automatic t_full_overflow();
        for (int i = 0; i < 62; i++) push_one(8'(i));
        check("R5", "nearly_full at 62", int'(nearly_full), 0);
        push_one(8'd62);
        check("R5", "nearly_full at 63", int'(nearly_full), 1);
        check("R4", "trig at 63", int'(trig_hit), 1);
        check("R3", "not full at 63", int'(full), 0);
        push_one(8'd63);
        check("R3", "full at 64", int'(full), 1);
        check("R3", "fill 64", int'(fill_level), 64);
        push_one(8'hEE);
        check("R6", "overflow pulse", int'(overflow_evt), 1);
        check("R6", "fill unchanged", int'(fill_level), 64);
        step();
        check("R6", "overflow single cycle", int'(overflow_evt), 0);
        // simultaneous push and pop at full
        push_valid = 1'b1; push_data = 8'hDD; pop_req = 1'b1;
        step();
        push_valid = 1'b0; pop_req = 1'b0;
        check("R8", "full both pop data", int'(pop_data), 0);
        check("R8", "full both fill", int'(fill_level), 63);
        check("R8", "full both overflow", int'(overflow_evt), 1);
        for (int i = 1; i < 64; i++) begin
            pop_one();
            check("R6", "drain order", int'(pop_data), i);
        end
        check("R6", "empty after drain", int'(empty), 1);
    endtask

    task automatic t_pop_empty();
        pop_one();
        check("R7", "empty pop data", int'(pop_data), 0);
        check("R7", "empty pop fill", int'(fill_level), 0);
    endtask

    task automatic t_both_empty();
        push_one(8'h41); pop_one(); // leave nonzero pop_data
        push_valid = 1'b1; push_data = 8'h5A; pop_req = 1'b1;
        step();
        push_valid = 1'b0; pop_req = 1'b0;
        check("R8", "empty both fill", int'(fill_level), 1);
        check("R8", "empty both data", int'(pop_data), 0);
        pop_one();
        check("R8", "empty both stored", int'(pop_data), 'h5A);
    endtask

    task automatic t_flush();
        push_one(8'h01); push_one(8'h02); push_one(8'h03);
        pop_one();
        path_flush = 1'b1; push_valid = 1'b1; push_data = 8'h77; pop_req = 1'b1;
        step();
        path_flush = 1'b0; push_valid = 1'b0; pop_req = 1'b0;
        check("R9", "flush fill", int'(fill_level), 0);
        check("R9", "flush empty", int'(empty), 1);
        check("R9", "flush pop_data", int'(pop_data), 0);
        check("R9", "flush_done pulse", int'(flush_done), 1);
        step();
        check("R9", "flush_done single", int'(flush_done), 0);
        push_one(8'h99); pop_one();
        check("R9", "fresh after flush", int'(pop_data), 'h99);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_order();
        t_trigger();
        t_full_overflow();
        t_pop_empty();
        t_both_empty();
        t_flush();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #800000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule